// File: doc/BRIEF.md
# Sub-word data FIFO access port

This block sits between a register bus and a byte-wide command/response FIFO. A bus access carries an address, a size code (one, two or four bytes) and, for writes, right-justified data. When the access lands on a data offset of the locality that currently owns the interface, the port moves the bytes of the access one per clock. On a write it pushes them into the command side of the FIFO. On a read it pops them from the response side. The first byte is the least significant one.

An access is clipped so that it never runs past the end of its 32-bit word. The legacy data offset and a 64-byte data window all reach the same FIFO. Accesses that miss the data offsets, or that come from a locality that may not use the FIFO, finish at once. They cause no FIFO traffic, and a read of this kind returns all ones. The FIFO control logic behind the port is seen only through push and pop strobes and their ready flags. That logic also supplies a flag saying a response is being held (completion), and while it is set written bytes are dropped.

Top module: `mmio_fifo_port`

## Requirements
- R1: Data offsets are decoded from address bits 11:0 with bits 1:0 cleared: 0x024, and every word offset from 0x080 to 0x0bc. An access to any other offset causes no push or pop. Such a read returns 0xffffffff.
- R2: The size code selects the write mask: 00 keeps 1 byte, 01 keeps 2 bytes, 10 and 11 keep 4 bytes. Bytes are pushed one per cycle, starting at req_wdata[7:0] and moving upward.
- R3: The byte count is the smaller of the size and 4 minus address bits 1:0.
- R4: A read places its first popped byte in rsp_rdata[7:0], the next in [15:8], and so on. Bytes beyond the count read as zero.
- R5: For each read byte position where pop_avail is low, the byte reads as 0xff and no pop is issued.
- R6: The locality is address bits 15:12. An access is rejected when owner_valid is low, when the locality is 5 or above, or when it differs from owner_loc. A rejected write pushes nothing. A rejected read pops nothing and returns 0xffffffff.
- R7: A write to locality 4 is rejected unless req_hw is high. A read from locality 4 is not affected by req_hw.
- R8: A write accepted while drop_writes is high pushes nothing.
- R9: A write stops in the first cycle in which push_ready is low. Its remaining bytes are discarded and the response is still issued.
- R10: req_ready stays low while a transfer is in progress. Each accepted request gets exactly one rsp_valid pulse. An access with n bytes and no stall responds n+1 cycles after the accepting edge. An access with no FIFO traffic responds 1 cycle after it.
- R11: After reset, req_ready is high and rsp_valid, push_valid and pop_req are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Bus request present |
| req_ready | output | 1 | Port can accept a request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_hw | input | 1 | Request originates from hardware |
| req_addr | input | ADDR_W | Byte address including the locality page |
| req_size | input | 2 | Size code: 00 byte, 01 half, 1x word |
| req_wdata | input | 32 | Right-justified write data |
| owner_valid | input | 1 | Some locality owns the interface |
| owner_loc | input | LOC_W | Owning locality |
| drop_writes | input | 1 | FIFO is holding a response; written bytes are dropped |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data, right-justified |
| push_valid | output | 1 | Command byte offered |
| push_data | output | 8 | Command byte |
| push_ready | input | 1 | FIFO accepts a command byte |
| pop_avail | input | 1 | Response byte available |
| pop_data | input | 8 | Current response byte |
| pop_req | output | 1 | Consume the current response byte |

## Verification
The bench uses the default parameters: a 16-bit address, 4 KB locality pages, five localities with locality 4 reserved for hardware writes, and a data window of 0x080 to 0x0bc. These values put the hardware-only page (0x4xxx) within reach, as well as the first page past the last locality (0x5xxx), both ends of the window and the word just past it (0x0c0). The bench models the FIFO with a bounded push space and a preloaded response queue. This lets every clipping offset, a stall partway through a write and a run dry partway through a read occur in a directed test.

// File: rtl/mmio_fifo_pkg.sv
// Package: shared constants and helpers for the sub-word data FIFO port.
// Assumes a 32-bit register bus carved into four byte lanes.
package mmio_fifo_pkg;
    localparam int BUS_BYTES = 4;
    localparam int BUS_W     = BUS_BYTES * 8;
    localparam int IDX_W     = $clog2(BUS_BYTES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WALT = 2'b11
    } size_code_e;

    // Keep-mask for right-justified write data of a given size code.
    function automatic logic [BUS_W-1:0] size_keep(input logic [1:0] code);
        case (code)
            SZ_BYTE: size_keep = BUS_W'(32'h0000_00ff);
            SZ_HALF: size_keep = BUS_W'(32'h0000_ffff);
            default: size_keep = '1;
        endcase
    endfunction

    // Byte count of a size code.
    function automatic logic [IDX_W:0] size_bytes(input logic [1:0] code);
        case (code)
            SZ_BYTE: size_bytes = (IDX_W+1)'(1);
            SZ_HALF: size_bytes = (IDX_W+1)'(2);
            default: size_bytes = (IDX_W+1)'(BUS_BYTES);
        endcase
    endfunction
endpackage

// File: rtl/mmio_fifo_decode.sv
// Module: mmio_fifo_decode
// Decodes one bus request: is it a data offset, may its locality use
// the FIFO, how many bytes it moves, and where its write bytes sit in the
// word lanes. Purely combinational; assumes offsets fit below PAGE_LSB.
module mmio_fifo_decode
    import mmio_fifo_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int PAGE_LSB   = 12,
    parameter int NUM_LOC    = 5,
    parameter int HW_LOC     = 4,
    parameter int LOC_W      = 3,
    parameter int LEGACY_OFF = 'h024,
    parameter int WIN_LO     = 'h080,
    parameter int WIN_HI     = 'h0bc
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic              write,
    input  logic              hw,
    input  logic              drop_writes,
    input  logic              owner_valid,
    input  logic [LOC_W-1:0]  owner_loc,
    input  logic [BUS_W-1:0]  wdata,
    output logic              go,
    output logic [IDX_W-1:0]  last_idx,
    output logic [IDX_W-1:0]  lane0,
    output logic [BUS_W-1:0]  lanes
);
    localparam int PAGE_W = ADDR_W - PAGE_LSB;
    localparam logic [PAGE_LSB-1:0] LEG_O = PAGE_LSB'(LEGACY_OFF);
    localparam logic [PAGE_LSB-1:0] WIN_L = PAGE_LSB'(WIN_LO);
    localparam logic [PAGE_LSB-1:0] WIN_H = PAGE_LSB'(WIN_HI);

    logic [PAGE_LSB-1:0] off;
    logic [PAGE_W-1:0]   page;
    logic                hit, owned, hw_block, dropped;
    logic [IDX_W:0]      room, want, cnt;

    // Offset and locality page split.
    always_comb begin
        off  = {addr[PAGE_LSB-1:IDX_W], {IDX_W{1'b0}}};
        page = addr[ADDR_W-1:PAGE_LSB];
    end

    // Data-offset hit and locality permission.
    always_comb begin
        hit      = (off == LEG_O) || (off >= WIN_L && off <= WIN_H);
        owned    = owner_valid && (int'(page) < NUM_LOC) &&
                   (int'(page) == int'(owner_loc));
        hw_block = write && (int'(page) == HW_LOC) && !hw;
        dropped  = write && drop_writes;
        go       = hit && owned && !hw_block && !dropped;
    end

    // Byte count clipped at the word boundary, and lane placement.
    always_comb begin
        lane0    = addr[IDX_W-1:0];
        room     = (IDX_W+1)'(BUS_BYTES) - {1'b0, lane0};
        want     = size_bytes(size);
        cnt      = (want < room) ? want : room;
        last_idx = IDX_W'(cnt - 1'b1);
        lanes    = (wdata & size_keep(size)) << {lane0, 3'b000};
    end
endmodule

// File: rtl/mmio_fifo_seq.sv
// Module: mmio_fifo_seq
// Moves the bytes of one accepted access, one per cycle: pushes write
// lanes upward from lane0, or packs pops (or the no-data byte) into a
// right-justified read word. Issues the single response pulse.
// Assumes start and reject never arrive while busy.
module mmio_fifo_seq
    import mmio_fifo_pkg::*;
#(
    parameter logic [7:0] NO_DATA = 8'hff
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             reject,
    input  logic             is_write,
    input  logic [IDX_W-1:0] last_idx,
    input  logic [IDX_W-1:0] lane0,
    input  logic [BUS_W-1:0] lanes,
    input  logic             push_ready,
    input  logic             pop_avail,
    input  logic [7:0]       pop_data,
    output logic             busy,
    output logic             push_valid,
    output logic [7:0]       push_data,
    output logic             pop_req,
    output logic             rsp_valid,
    output logic [BUS_W-1:0] rsp_rdata
);
    logic             wr_q;
    logic [IDX_W-1:0] idx_q, last_q, lane0_q, cur_lane;
    logic [BUS_W-1:0] lanes_q, rbuf_q, rd_merged;
    logic [7:0]       rd_byte;
    logic             step_done;

    // Current byte selection and completion condition.
    always_comb begin
        cur_lane   = lane0_q + idx_q;
        push_data  = lanes_q[{cur_lane, 3'b000} +: 8];
        push_valid = busy && wr_q;
        pop_req    = busy && !wr_q && pop_avail;
        rd_byte    = pop_avail ? pop_data : NO_DATA;
        rd_merged  = rbuf_q | (BUS_W'(rd_byte) << {idx_q, 3'b000});
        step_done  = wr_q ? (!push_ready || idx_q == last_q) : (idx_q == last_q);
    end

    // Transfer state, read packing and response register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            wr_q      <= 1'b0;
            idx_q     <= '0;
            last_q    <= '0;
            lane0_q   <= '0;
            lanes_q   <= '0;
            rbuf_q    <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (start) begin
                busy    <= 1'b1;
                wr_q    <= is_write;
                idx_q   <= '0;
                last_q  <= last_idx;
                lane0_q <= lane0;
                lanes_q <= lanes;
                rbuf_q  <= '0;
            end else if (reject) begin
                rsp_valid <= 1'b1;
                rsp_rdata <= '1;
            end else if (busy) begin
                if (!wr_q) rbuf_q <= rd_merged;
                if (step_done) begin
                    busy      <= 1'b0;
                    rsp_valid <= 1'b1;
                    rsp_rdata <= wr_q ? '0 : rd_merged;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    // Clipping keeps every written lane inside the word (R3).
    assert_lane_in_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid |-> ({1'b0, lane0_q} + {1'b0, idx_q} < (IDX_W+1)'(BUS_BYTES)));

    // A refused push ends the write on the next edge (R9).
    assert_stop_on_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && !push_ready) |=> !busy);
endmodule

// File: rtl/mmio_fifo_port.sv
// Module: mmio_fifo_port (top)
// Register-bus port onto a byte-serial command/response FIFO. Decodes the
// data offsets and locality rules, then hands accepted accesses to the
// byte sequencer. One access is in flight at a time.
module mmio_fifo_port
    import mmio_fifo_pkg::*;
#(
    parameter int         ADDR_W     = 16,
    parameter int         PAGE_LSB   = 12,
    parameter int         NUM_LOC    = 5,
    parameter int         HW_LOC     = 4,
    parameter int         LOC_W      = 3,
    parameter int         LEGACY_OFF = 'h024,
    parameter int         WIN_LO     = 'h080,
    parameter int         WIN_HI     = 'h0bc,
    parameter logic [7:0] NO_DATA    = 8'hff
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_hw,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [31:0]       req_wdata,
    input  logic              owner_valid,
    input  logic [LOC_W-1:0]  owner_loc,
    input  logic              drop_writes,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              push_valid,
    output logic [7:0]        push_data,
    input  logic              push_ready,
    input  logic              pop_avail,
    input  logic [7:0]        pop_data,
    output logic              pop_req
);
    logic             go, busy, accept;
    logic [IDX_W-1:0] last_idx, lane0;
    logic [BUS_W-1:0] lanes;

    // Request acceptance: only when no transfer is in flight.
    always_comb begin
        req_ready = !busy;
        accept    = req_valid && req_ready;
    end

    mmio_fifo_decode #(
        .ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB), .NUM_LOC(NUM_LOC),
        .HW_LOC(HW_LOC), .LOC_W(LOC_W), .LEGACY_OFF(LEGACY_OFF),
        .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)
    ) u_decode (
        .addr(req_addr), .size(req_size), .write(req_write), .hw(req_hw),
        .drop_writes(drop_writes), .owner_valid(owner_valid),
        .owner_loc(owner_loc), .wdata(req_wdata), .go(go),
        .last_idx(last_idx), .lane0(lane0), .lanes(lanes)
    );

    mmio_fifo_seq #(.NO_DATA(NO_DATA)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(accept && go),
        .reject(accept && !go), .is_write(req_write), .last_idx(last_idx),
        .lane0(lane0), .lanes(lanes), .push_ready(push_ready),
        .pop_avail(pop_avail), .pop_data(pop_data), .busy(busy),
        .push_valid(push_valid), .push_data(push_data), .pop_req(pop_req),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    // A refused read answers all ones on the next cycle (R6).
    assert_reject_all_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !go && !req_write) |=> (rsp_valid && rsp_rdata == 32'hffff_ffff));

    // A started transfer holds the bus off (R10).
    assert_busy_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && go) |=> !req_ready);

    // A write during completion never reaches the FIFO (R8).
    assert_drop_no_push_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_write && drop_writes) |=> !push_valid);

    // Idle port never touches the FIFO (R1).
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !$past(accept)) |-> (!push_valid && !pop_req));
endmodule

// File: tb/mmio_fifo_port_bench.sv
`timescale 1ns/1ps
// Directed bench for mmio_fifo_port with a behavioural FIFO model.
module mmio_fifo_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_hw = 1'b0;
    logic [15:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        owner_valid = 1'b0, drop_writes = 1'b0;
    logic [2:0]  owner_loc = '0;
    logic        req_ready, rsp_valid, push_valid, pop_req;
    logic [31:0] rsp_rdata;
    logic [7:0]  push_data;
    logic        push_ready, pop_avail;
    logic [7:0]  pop_data;

    int n_chk = 0, n_err = 0;

    // FIFO model: response queue and push log.
    logic [7:0] rq [0:63];
    logic [7:0] pl [0:127];
    int rq_wr = 0, rq_rd = 0, pl_n = 0;
    int sp_base = 0, sp_lim = 1000;

    assign pop_avail  = rq_rd < rq_wr;
    assign pop_data   = rq[rq_rd[5:0]];
    assign push_ready = (pl_n - sp_base) < sp_lim;

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (pop_req) rq_rd <= rq_rd + 1;
        if (push_valid && push_ready) begin
            pl[pl_n[6:0]] <= push_data;
            pl_n <= pl_n + 1;
        end
    end

    mmio_fifo_port u_mmio_fifo_port (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_hw(req_hw), .req_addr(req_addr),
        .req_size(req_size), .req_wdata(req_wdata), .owner_valid(owner_valid),
        .owner_loc(owner_loc), .drop_writes(drop_writes), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .push_valid(push_valid), .push_data(push_data),
        .push_ready(push_ready), .pop_avail(pop_avail), .pop_data(pop_data),
        .pop_req(pop_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one access and wait for its response.
    task automatic acc(input logic wr, input logic [15:0] a, input logic [1:0] sz,
                       input logic [31:0] wd, input logic hw,
                       output logic [31:0] rd, output int lat);
        @(negedge clk);
        req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
        req_hw = hw; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        rd = rsp_rdata;
    endtask

    task automatic expect_pushes(input string tag, input int base, input int n,
                                 input logic [31:0] bytes);
        chk({tag, " push count"}, 32'(pl_n - base), 32'(n));
        for (int i = 0; i < n; i++)
            chk({tag, " push byte"}, {24'h0, pl[(base + i) % 128]}, {24'h0, bytes[8*i +: 8]});
    endtask

    task automatic load_rsp(input int n, input logic [31:0] bytes);
        for (int i = 0; i < n; i++) begin
            rq[rq_wr[5:0]] = bytes[8*i +: 8];
            rq_wr++;
        end
    endtask

    task automatic t_reset;
        chk("R11 req_ready", {31'h0, req_ready}, 32'h1);
        chk("R11 rsp_valid", {31'h0, rsp_valid}, 32'h0);
        chk("R11 push_valid", {31'h0, push_valid}, 32'h0);
        chk("R11 pop_req", {31'h0, pop_req}, 32'h0);
    endtask

    task automatic t_write_word;
        logic [31:0] rd; int lat, b;
        b = pl_n;
        @(negedge clk);
        req_write = 1; req_addr = 16'h0024; req_size = 2'b10;
        req_wdata = 32'h4433_2211; req_hw = 0; req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        chk("R10 req_ready low in transfer", {31'h0, req_ready}, 32'h0);
        lat = 1;
        while (!rsp_valid && lat < 40) begin @(negedge clk); lat++; end
        chk("R10 word latency", 32'(lat), 32'd5);
        expect_pushes("R2 word", b, 4, 32'h4433_2211);
        @(negedge clk);
        chk("R10 single pulse", {31'h0, rsp_valid}, 32'h0);
    endtask

    task automatic t_write_sizes;
        logic [31:0] rd; int lat, b;
        b = pl_n;
        acc(1, 16'h0024, 2'b00, 32'haabb_ccdd, 0, rd, lat);
        expect_pushes("R2 byte size", b, 1, 32'h0000_00dd);
        chk("R10 byte latency", 32'(lat), 32'd2);
        b = pl_n;
        acc(1, 16'h0084, 2'b01, 32'h1234_5678, 0, rd, lat);
        expect_pushes("R2 R1 half in window", b, 2, 32'h0000_5678);
    endtask

    task automatic t_clip;
        logic [31:0] rd; int lat, b;
        b = pl_n;
        acc(1, 16'h0026, 2'b10, 32'h8899_aabb, 0, rd, lat);
        expect_pushes("R3 word at lane 2", b, 2, 32'h0000_aabb);
        chk("R3 clipped latency", 32'(lat), 32'd3);
        b = pl_n;
        acc(1, 16'h0027, 2'b01, 32'h0000_c3c4, 0, rd, lat);
        expect_pushes("R3 half at lane 3", b, 1, 32'h0000_00c4);
    endtask

    task automatic t_read;
        logic [31:0] rd; int lat;
        load_rsp(4, 32'h0403_0201);
        acc(0, 16'h00bc, 2'b10, 32'h0, 0, rd, lat);
        chk("R4 R1 word read at window end", rd, 32'h0403_0201);
        load_rsp(2, 32'h0000_0605);
        acc(0, 16'h0025, 2'b01, 32'h0, 0, rd, lat);
        chk("R4 half read upper zero", rd, 32'h0000_0605);
    endtask

    task automatic t_nodata;
        logic [31:0] rd; int lat, r0;
        r0 = rq_rd;
        load_rsp(1, 32'h0000_005a);
        acc(0, 16'h0024, 2'b10, 32'h0, 0, rd, lat);
        chk("R5 run dry fills 0xff", rd, 32'hffff_ff5a);
        chk("R5 only one pop", 32'(rq_rd - r0), 32'd1);
    endtask

    task automatic t_undecoded;
        logic [31:0] rd; int lat, b;
        acc(0, 16'h0028, 2'b10, 32'h0, 0, rd, lat);
        chk("R1 undecoded read", rd, 32'hffff_ffff);
        chk("R1 undecoded latency", 32'(lat), 32'd1);
        b = pl_n;
        acc(1, 16'h0018, 2'b10, 32'h1111_1111, 0, rd, lat);
        acc(1, 16'h00c0, 2'b10, 32'h2222_2222, 0, rd, lat);
        chk("R1 no push off window", 32'(pl_n - b), 32'd0);
    endtask

    task automatic t_locality;
        logic [31:0] rd; int lat, b, r0;
        b = pl_n;
        acc(1, 16'h1024, 2'b10, 32'h5555_5555, 0, rd, lat);
        chk("R6 foreign write ignored", 32'(pl_n - b), 32'd0);
        load_rsp(1, 32'h0000_0033);
        r0 = rq_rd;
        acc(0, 16'h1024, 2'b10, 32'h0, 0, rd, lat);
        chk("R6 foreign read all ones", rd, 32'hffff_ffff);
        chk("R6 foreign read no pop", 32'(rq_rd - r0), 32'd0);
        owner_valid = 0;
        acc(1, 16'h0024, 2'b00, 32'h66, 0, rd, lat);
        chk("R6 no owner write ignored", 32'(pl_n - b), 32'd0);
        owner_valid = 1; owner_loc = 3'd5;
        acc(1, 16'h5024, 2'b00, 32'h77, 1, rd, lat);
        chk("R6 page 5 out of range", 32'(pl_n - b), 32'd0);
        owner_loc = 3'd0;
        acc(0, 16'h0024, 2'b00, 32'h0, 0, rd, lat);   // drain the 0x33 byte
        chk("R6 queue intact after refusal", rd, 32'h0000_0033);
    endtask

    task automatic t_hw_loc;
        logic [31:0] rd; int lat, b;
        owner_loc = 3'd4;
        b = pl_n;
        acc(1, 16'h4024, 2'b00, 32'h91, 0, rd, lat);
        chk("R7 loc4 write without hw", 32'(pl_n - b), 32'd0);
        acc(1, 16'h4024, 2'b00, 32'h92, 1, rd, lat);
        expect_pushes("R7 loc4 write with hw", b, 1, 32'h92);
        load_rsp(1, 32'h77);
        acc(0, 16'h4024, 2'b00, 32'h0, 0, rd, lat);
        chk("R7 loc4 read without hw", rd, 32'h0000_0077);
        owner_loc = 3'd0;
    endtask

    task automatic t_drop;
        logic [31:0] rd; int lat, b;
        b = pl_n;
        drop_writes = 1;
        acc(1, 16'h0024, 2'b10, 32'hdead_beef, 0, rd, lat);
        drop_writes = 0;
        chk("R8 dropped write pushes", 32'(pl_n - b), 32'd0);
        chk("R8 dropped write responds", 32'(lat), 32'd1);
    endtask

    task automatic t_backpressure;
        logic [31:0] rd; int lat, b;
        b = pl_n; sp_base = pl_n; sp_lim = 2;
        acc(1, 16'h0024, 2'b10, 32'hf4f3_f2f1, 0, rd, lat);
        expect_pushes("R9 stalled write", b, 2, 32'h0000_f2f1);
        chk("R9 stalled latency", 32'(lat), 32'd4);
        b = pl_n; sp_base = pl_n; sp_lim = 0;
        acc(1, 16'h0024, 2'b10, 32'h0102_0304, 0, rd, lat);
        chk("R9 full fifo pushes", 32'(pl_n - b), 32'd0);
        chk("R9 full fifo latency", 32'(lat), 32'd2);
        sp_lim = 1000;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        owner_valid = 1; owner_loc = 3'd0;
        t_write_word;
        t_write_sizes;
        t_clip;
        t_read;
        t_nodata;
        t_undecoded;
        t_locality;
        t_hw_loc;
        t_drop;
        t_backpressure;
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule